// File: doc/BRIEF.md
# Quadword Load Sequencer

This block carries out one 128-bit load into an even/odd pair of 64-bit general registers. A decode stage presents the destination and base register numbers, the base register value, a signed displacement and three mode flags: user mode, little-endian mode, and a flag that enables the newer behaviour of the load. One start pulse hands these over. The block checks whether the load is legal. If it is not, it reports an exception code. If it is, it computes an aligned effective address, issues two 64-bit reads on a simple request/response memory port and writes each returned doubleword into the register file through one write port.

When the enable flag is clear, the load is privileged and does not support little-endian mode. When the flag is set, the load may run in user mode and in little-endian mode. In little-endian mode the doubleword from the lower address goes to the odd register of the pair. A single-cycle done pulse ends every operation, successful or not.

Top module: `quadload_seq`

## Requirements
- R1: With the enable flag clear and user mode set, the block reports exception code 1 (privileged) and makes no memory request.
- R2: With the enable flag clear, user mode clear and little-endian mode set, the block reports exception code 2 (alignment, little-endian) and makes no memory request.
- R3: Otherwise, if the destination number is odd or equals the base number, the block reports exception code 3 (invalid form) and makes no memory request. Only the first applicable condition of R1, R2 and R3, in that order, is reported.
- R4: The effective address is the base value plus the sign-extended displacement with its low 4 bits cleared. A base register number of 0 selects a base value of 0.
- R5: A legal load issues exactly two reads: the first at the effective address and the second at the effective address plus 8. Each request and its address stay steady until the response-valid cycle.
- R6: In big-endian mode the first doubleword is written to register rd and the second to rd+1. Each write happens in the cycle its response is valid, with the response data.
- R7: In little-endian mode with the enable flag set, the first doubleword is written to rd+1 and the second to rd.
- R8: Every operation ends with exactly one single-cycle done pulse. The exception code is valid in that cycle and is 0 after a successful load.
- R9: A start pulse that arrives while an operation is in flight is ignored.
- R10: After reset the block makes no request, no register write and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; operands are captured when idle |
| rd_i | input | 5 | Destination register number (pair base) |
| ra_i | input | 5 | Base register number |
| base_i | input | 64 | Value of the base register |
| disp_i | input | 16 | Signed displacement |
| user_i | input | 1 | Core is in user mode |
| le_i | input | 1 | Core is in little-endian mode |
| feat_i | input | 1 | Enables user-mode and little-endian use of the load |
| mem_req_o | output | 1 | Read request, held until the response |
| mem_addr_o | output | 64 | Read address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 64 | Read response data |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 5 | Register file write index |
| rf_wdata_o | output | 64 | Register file write data |
| done_o | output | 1 | Single-cycle completion pulse |
| exc_o | output | 2 | Exception code: 0 none, 1 privileged, 2 alignment LE, 3 invalid form |

## Verification
The sweep covers every combination of the three mode flags with all 32 destination numbers. Each destination is paired with three base numbers: zero, the destination itself, and an unrelated register. Together these separate the priority between the three exception kinds, tell an odd or overlapping destination apart from a legal one, and show whether register 0 is read as zero. The displacements include negative values and values with nonzero low bits, so a missing sign extension or a missing alignment mask shows up as a wrong address. Response latencies of zero to two cycles test the hold of the request, and a start pulse sent in mid-operation tests that the block ignores it.

// File: rtl/quadload_pkg.sv
package quadload_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_CHECK = 3'd1,
        S_READ0 = 3'd2,
        S_READ1 = 3'd3,
        S_DONE  = 3'd4
    } qstate_e;

    typedef enum logic [1:0] {
        EXC_NONE     = 2'd0,
        EXC_PRIV     = 2'd1,
        EXC_ALIGN_LE = 2'd2,
        EXC_FORM     = 2'd3
    } qexc_e;

endpackage

// File: rtl/quadload_legal.sv
module quadload_legal
    import quadload_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              user_i,
    input  logic              le_i,
    input  logic              feat_i,
    input  logic [REG_AW-1:0] rd_i,
    input  logic [REG_AW-1:0] ra_i,
    output qexc_e             exc_o
);

    // priority: privilege, then endianness support, then register form
    always_comb begin
        if (!feat_i && user_i) begin
            exc_o = EXC_PRIV;
        end else if (!feat_i && le_i) begin
            exc_o = EXC_ALIGN_LE;
        end else if (rd_i[0] || (rd_i == ra_i)) begin
            exc_o = EXC_FORM;
        end else begin
            exc_o = EXC_NONE;
        end
    end

endmodule

// File: rtl/quadload_agen.sv
module quadload_agen #(
    parameter int XLEN   = 64,
    parameter int DISP_W = 16,
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] ra_i,
    input  logic [XLEN-1:0]   base_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic              beat_i,
    output logic [XLEN-1:0]   addr_o
);

    localparam int ALIGN_BITS = 4;
    localparam int BEAT_BYTES = XLEN / 8;

    logic [XLEN-1:0] base_eff;
    logic [XLEN-1:0] disp_ext;
    logic [XLEN-1:0] ea;

    always_comb begin
        base_eff = (ra_i == '0) ? '0 : base_i;
        disp_ext = {{(XLEN-DISP_W){disp_i[DISP_W-1]}},
                    disp_i[DISP_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        ea       = base_eff + disp_ext;
        addr_o   = beat_i ? (ea + XLEN'(BEAT_BYTES)) : ea;
    end

endmodule

// File: rtl/quadload_steer.sv
module quadload_steer #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] rd_i,
    input  logic              le_i,
    input  logic              beat_i,
    output logic [REG_AW-1:0] waddr_o
);

    // lower-address beat goes to the even register unless little-endian
    always_comb begin
        waddr_o = {rd_i[REG_AW-1:1], beat_i ^ le_i};
    end

endmodule

// File: rtl/quadload_seq.sv
module quadload_seq
    import quadload_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int DISP_W = 16,
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [REG_AW-1:0] rd_i,
    input  logic [REG_AW-1:0] ra_i,
    input  logic [XLEN-1:0]   base_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic              user_i,
    input  logic              le_i,
    input  logic              feat_i,
    output logic              mem_req_o,
    output logic [XLEN-1:0]   mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [XLEN-1:0]   mem_rdata_i,
    output logic              rf_we_o,
    output logic [REG_AW-1:0] rf_waddr_o,
    output logic [XLEN-1:0]   rf_wdata_o,
    output logic              done_o,
    output logic [1:0]        exc_o
);

    localparam int BEAT_BYTES = XLEN / 8;

    typedef struct packed {
        qstate_e           st;
        logic [REG_AW-1:0] rd;
        logic [REG_AW-1:0] ra;
        logic [XLEN-1:0]   base;
        logic [DISP_W-1:0] disp;
        logic              user;
        logic              le;
        logic              feat;
        qexc_e             exc;
    } ctx_t;

    ctx_t  ctx_d, ctx_q;
    qexc_e chk_exc;
    logic  beat;
    logic  in_read;

    quadload_legal #(.REG_AW(REG_AW)) u_legal (
        .user_i (ctx_q.user),
        .le_i   (ctx_q.le),
        .feat_i (ctx_q.feat),
        .rd_i   (ctx_q.rd),
        .ra_i   (ctx_q.ra),
        .exc_o  (chk_exc)
    );

    quadload_agen #(.XLEN(XLEN), .DISP_W(DISP_W), .REG_AW(REG_AW)) u_agen (
        .ra_i   (ctx_q.ra),
        .base_i (ctx_q.base),
        .disp_i (ctx_q.disp),
        .beat_i (beat),
        .addr_o (mem_addr_o)
    );

    quadload_steer #(.REG_AW(REG_AW)) u_steer (
        .rd_i    (ctx_q.rd),
        .le_i    (ctx_q.le),
        .beat_i  (beat),
        .waddr_o (rf_waddr_o)
    );

    always_comb begin
        beat    = (ctx_q.st == S_READ1);
        in_read = (ctx_q.st == S_READ0) || (ctx_q.st == S_READ1);
    end

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            S_IDLE: begin
                if (start_i) begin
                    ctx_d.st   = S_CHECK;
                    ctx_d.rd   = rd_i;
                    ctx_d.ra   = ra_i;
                    ctx_d.base = base_i;
                    ctx_d.disp = disp_i;
                    ctx_d.user = user_i;
                    ctx_d.le   = le_i;
                    ctx_d.feat = feat_i;
                    ctx_d.exc  = EXC_NONE;
                end
            end
            S_CHECK: begin
                ctx_d.exc = chk_exc;
                ctx_d.st  = (chk_exc != EXC_NONE) ? S_DONE : S_READ0;
            end
            S_READ0: begin
                if (mem_rvalid_i) ctx_d.st = S_READ1;
            end
            S_READ1: begin
                if (mem_rvalid_i) ctx_d.st = S_DONE;
            end
            S_DONE: begin
                ctx_d.st = S_IDLE;
            end
            default: ctx_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: S_IDLE, exc: EXC_NONE, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    always_comb begin
        mem_req_o  = in_read;
        rf_we_o    = in_read && mem_rvalid_i;
        rf_wdata_o = mem_rdata_i;
        done_o     = (ctx_q.st == S_DONE);
        exc_o      = done_o ? ctx_q.exc : EXC_NONE;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o))) // R5
        else $error("request dropped or address moved before response");

    AST_BEAT_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && !beat) |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + XLEN'(BEAT_BYTES))) // R5
        else $error("second read not at first address plus 8");

    AST_PAIR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (rf_waddr_o[REG_AW-1:1] == ctx_q.rd[REG_AW-1:1])) // R6
        else $error("write left the destination pair");

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) // R8
        else $error("done lasted more than one cycle");

    AST_EXC_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st == S_CHECK && chk_exc != EXC_NONE) |=> (!mem_req_o && done_o)) // R1
        else $error("memory touched after an exception");

endmodule

// File: tb/quadload_seq_test.sv
`timescale 1ns/1ps
module quadload_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  rd_i = '0;
    logic [4:0]  ra_i = '0;
    logic [63:0] base_i = '0;
    logic [15:0] disp_i = '0;
    logic        user_i = 1'b0;
    logic        le_i = 1'b0;
    logic        feat_i = 1'b0;
    logic        mem_req_o;
    logic [63:0] mem_addr_o;
    logic        mem_rvalid_i = 1'b0;
    logic [63:0] mem_rdata_i = '0;
    logic        rf_we_o;
    logic [4:0]  rf_waddr_o;
    logic [63:0] rf_wdata_o;
    logic        done_o;
    logic [1:0]  exc_o;

    int n_checks = 0;
    int n_fail = 0;
    int latency = 0;
    int lat_cnt = 0;
    int cycles = 0;

    logic [4:0]  wr_addr [4];
    logic [63:0] wr_data [4];
    logic [63:0] wr_mem  [4];
    int nw = 0;
    int req_seen = 0;
    int ndone = 0;
    logic [1:0] exc_seen = '0;

    always #5 clk = ~clk;

    quadload_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i), .ra_i(ra_i),
        .base_i(base_i), .disp_i(disp_i), .user_i(user_i), .le_i(le_i), .feat_i(feat_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
        .mem_rdata_i(mem_rdata_i), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
        .rf_wdata_o(rf_wdata_o), .done_o(done_o), .exc_o(exc_o)
    );

    function automatic logic [63:0] mem_word(input logic [63:0] a);
        return {a[31:0] ^ 32'h5A5A_C3C3, ~a[31:0]};
    endfunction

    task automatic report_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // memory model: answers a held request after `latency` idle cycles
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rvalid_i) begin
                mem_rvalid_i = 1'b0;
            end else if (mem_req_o) begin
                if (lat_cnt >= latency) begin
                    mem_rvalid_i = 1'b1;
                    mem_rdata_i  = mem_word(mem_addr_o);
                    lat_cnt = 0;
                end else begin
                    lat_cnt++;
                end
            end
        end
    end

    // observer, sampled between edges
    always @(negedge clk) begin
        #2;
        if (rf_we_o) begin
            if (nw < 4) begin
                wr_addr[nw] = rf_waddr_o;
                wr_data[nw] = rf_wdata_o;
                wr_mem[nw]  = mem_addr_o;
            end
            nw++;
        end
        if (mem_req_o) req_seen++;
        if (done_o) begin
            ndone++;
            exc_seen = exc_o;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            report_end();
        end
    end

    task automatic run_op(input bit f, input bit u, input bit l, input logic [4:0] rd,
                          input logic [4:0] ra, input logic [63:0] base, input logic [15:0] disp,
                          input int lat, input bit poke);
        logic [1:0]  exp_exc;
        logic [63:0] ea;
        logic [63:0] b_eff;
        logic [4:0]  first_reg;
        logic [4:0]  second_reg;
        int waited;
        @(negedge clk);
        latency = lat; lat_cnt = 0;
        nw = 0; req_seen = 0; ndone = 0; exc_seen = '0;
        feat_i = f; user_i = u; le_i = l; rd_i = rd; ra_i = ra; base_i = base; disp_i = disp;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            // R9: stray start mid-operation with different operands
            @(negedge clk);
            rd_i = 5'd10; ra_i = 5'd0; le_i = ~l; base_i = 64'hDEAD_0000; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        waited = 0;
        while (ndone == 0 && waited < 60) begin
            @(negedge clk);
            waited++;
        end
        repeat (6) @(negedge clk);

        if (!f && u) exp_exc = 2'd1;
        else if (!f && l) exp_exc = 2'd2;
        else if (rd[0] || rd == ra) exp_exc = 2'd3;
        else exp_exc = 2'd0;

        check(ndone == 1, "R8 one done pulse", 64'(ndone), 64'd1);
        if (exp_exc == 2'd1)      check(exc_seen == exp_exc, "R1 exception code", 64'(exc_seen), 64'(exp_exc));
        else if (exp_exc == 2'd2) check(exc_seen == exp_exc, "R2 exception code", 64'(exc_seen), 64'(exp_exc));
        else if (exp_exc == 2'd3) check(exc_seen == exp_exc, "R3 exception code", 64'(exc_seen), 64'(exp_exc));
        else                      check(exc_seen == exp_exc, "R8 success code", 64'(exc_seen), 64'(exp_exc));

        if (exp_exc != 2'd0) begin
            check(req_seen == 0 && nw == 0, "R1/R2/R3 no access", 64'(req_seen), 64'd0);
        end else begin
            b_eff = (ra == 5'd0) ? 64'd0 : base;
            ea = b_eff + {{48{disp[15]}}, disp[15:4], 4'b0000};
            first_reg  = l ? {rd[4:1], 1'b1} : rd;
            second_reg = l ? rd : {rd[4:1], 1'b1};
            check(nw == 2, "R5 two writes", 64'(nw), 64'd2);
            if (nw == 2) begin
                check(wr_mem[0] == ea, "R4 first address", wr_mem[0], ea);
                check(wr_mem[1] == ea + 64'd8, "R5 second address", wr_mem[1], ea + 64'd8);
                if (l) begin
                    check(wr_addr[0] == first_reg, "R7 first target", 64'(wr_addr[0]), 64'(first_reg));
                    check(wr_addr[1] == second_reg, "R7 second target", 64'(wr_addr[1]), 64'(second_reg));
                end else begin
                    check(wr_addr[0] == first_reg, "R6 first target", 64'(wr_addr[0]), 64'(first_reg));
                    check(wr_addr[1] == second_reg, "R6 second target", 64'(wr_addr[1]), 64'(second_reg));
                end
                check(wr_data[0] == mem_word(ea), "R6 first data", wr_data[0], mem_word(ea));
                check(wr_data[1] == mem_word(ea + 64'd8), "R6 second data", wr_data[1], mem_word(ea + 64'd8));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!mem_req_o && !rf_we_o && !done_o, "R10 quiet in reset",
              {61'd0, mem_req_o, rf_we_o, done_o}, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!mem_req_o && !rf_we_o && !done_o, "R10 quiet after reset",
              {61'd0, mem_req_o, rf_we_o, done_o}, 64'd0);

        for (int m = 0; m < 8; m++) begin
            for (int r = 0; r < 32; r++) begin
                for (int s = 0; s < 3; s++) begin
                    logic [4:0]  ra;
                    logic [63:0] base;
                    logic [15:0] disp;
                    ra   = (s == 0) ? 5'd0 : (s == 1) ? 5'(r) : 5'((r + 7) % 32);
                    base = 64'h1000_0000_0000_0000 + 64'(r) * 64'h0123_4567 + 64'(ra);
                    disp = 16'((r * 1237) ^ (s * 20077));
                    run_op(m[2], m[1], m[0], 5'(r), ra, base, disp, (r + s) % 3, 1'b0);
                end
            end
        end

        // R9 ignored start, both endian modes
        run_op(1'b1, 1'b1, 1'b0, 5'd4, 5'd9, 64'h0000_7000_0000_0040, 16'h8013, 2, 1'b1);
        run_op(1'b1, 1'b0, 1'b1, 5'd4, 5'd9, 64'h0000_7000_0000_0040, 16'h7FFF, 2, 1'b1);

        report_end();
    end

endmodule